// File: doc/BRIEF.md
# Line-Locked Clock Coast Window Generator

This block drives the coast request for a line-locked pixel clock generator. While coast is high, the clock generator stops following horizontal sync and holds its current frequency. This covers the vertical sync interval, where equalization and serration pulses would otherwise pull the loop off frequency. The block takes horizontal and vertical sync that are already synchronous to the system clock and active high. It also takes an optional external coast input and four configuration values. From these it builds one active-high coast output.

The window around vertical sync has three parts:
- An early part that opens a programmable number of lines before the vertical sync rising edge. Its position is predicted from the line count of the previous frame.
- The vertical sync interval itself.
- A late part that stays open for a programmable number of horizontal sync edges after vertical sync falls.

The external coast input is ORed in after its polarity is corrected. The polarity is either forced by the user or found by a duty-cycle detector, and the detector's result is also reported as a status bit.

Top module: `coast_window_gen`

## Requirements
- R1: While `rst_n` is low, `coast_o` is 0 and `coast_pol_det_o` is 1. The internal logic leaves reset on the second rising clock edge after `rst_n` rises.
- R2: The frame length is the number of rising edges of `hsync_i` between two consecutive rising edges of `vsync_i`. The first vertical rising edge after reset only starts counting. From the second one on, a frame length is held. A horizontal rising edge in the same cycle as a vertical rising edge is counted in neither frame.
- R3: `coast_o` is a register. In the cycle after `vsync_i` is sampled high, `coast_o` is 1.
- R4: Once a frame length is held, coast is asserted when `pre_lines_i` is nonzero and (lines counted since the last vertical rising edge + `pre_lines_i`) >= the held frame length. If `pre_lines_i` is 0, there is no early window.
- R5: When `vsync_i` falls, a late-window counter loads `post_lines_i`. Coast is held until that many further `hsync_i` rising edges have been seen. A horizontal edge in the same cycle as the vertical fall does not count down. With `post_lines_i` = 0, coast drops right after the vertical interval.
- R6: The active level of `coast_ext_i` is `pol_user_i` when `pol_force_i` is 1, and the detected polarity otherwise. A value of 1 means active high. While `coast_ext_i` is at its active level, coast is asserted.
- R7: The detector looks at windows of 256 cycles. At the end of each window, `coast_pol_det_o` becomes 1 if `coast_ext_i` was high for fewer cycles than it was low, and 0 if it was high for more cycles. On a tie it keeps its value.
- R8: `coast_o` is 0 in the cycle after a sample in which none of these is active: vertical sync, the early window, the late window, or an active external input.
- R9: Until a frame length has been measured, `pre_lines_i` has no effect on `coast_o`.
- R10: When edges of `hsync_i` and `vsync_i` fall in the same cycle, they are handled as R2 and R5 state, and coast shows no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, active high, system clock domain |
| vsync_i | input | 1 | Vertical sync, active high, system clock domain |
| coast_ext_i | input | 1 | External coast request, polarity unknown |
| pre_lines_i | input | 8 | Lines of coast before vertical sync |
| post_lines_i | input | 8 | Lines of coast after vertical sync |
| pol_force_i | input | 1 | 1: use pol_user_i, 0: use detected polarity |
| pol_user_i | input | 1 | Forced external polarity, 1 = active high |
| coast_o | output | 1 | Coast request, active high |
| coast_pol_det_o | output | 1 | Detected external coast polarity, 1 = positive |

## Verification
A horizontal sync rising edge can land in the same cycle as either edge of vertical sync. At a vertical rise it competes with the line-count clear. At a vertical fall it competes with the load of the late-window counter. The bench provokes both by placing the vertical edges of some frames exactly on a horizontal rising edge and others a few cycles off. It judges the outcome by comparing `coast_o` every cycle against a model built from R2 and R5. A miscounted line or an extra countdown shows up there as an early window one line off or a late window one line short.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  typedef enum logic {
    POL_NEG = 1'b0,
    POL_POS = 1'b1
  } pol_e;
endpackage

// File: rtl/cwg_line_track.sv
module cwg_line_track #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              hs_rise_i,
  input  logic              vs_rise_i,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic [LINE_W-1:0] frame_len_o,
  output logic              len_valid_o
);
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  logic [LINE_W-1:0] cnt_q, cnt_d, len_q;
  logic              started_q, started_d, valid_q, valid_d, len_en;

  always_comb begin
    cnt_d = cnt_q;
    if (vs_rise_i)                         cnt_d = '0;
    else if (hs_rise_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    len_en    = vs_rise_i & started_q;
    started_d = started_q | vs_rise_i;
    valid_d   = valid_q | len_en;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      started_q <= started_d;
      valid_q   <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (len_en) len_q <= cnt_q;
  end

  assign line_cnt_o  = cnt_q;
  assign frame_len_o = len_q;
  assign len_valid_o = valid_q;

  // R2: the held length only moves on a vertical rising edge
  p_len_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !vs_rise_i |=> $stable(len_q));
  // R2: once measured, a frame length stays valid
  p_valid_sticky_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_q |=> valid_q);
endmodule

// File: rtl/cwg_pol_detect.sv
module cwg_pol_detect
  import cwg_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic level_i,
  output pol_e pol_o
);
  localparam logic [WIN_W+1:0] WIN_LEN = (WIN_W+2)'(1) << WIN_W;

  logic [WIN_W-1:0] win_q, win_d;
  logic [WIN_W:0]   hi_q, hi_d, hi_sum;
  logic [WIN_W+1:0] hi_dbl;
  logic             win_end;
  pol_e             det_q, det_d;

  always_comb begin
    win_end = &win_q;
    win_d   = win_q + 1'b1;
    hi_sum  = hi_q + {{WIN_W{1'b0}}, level_i};
    hi_dbl  = {hi_sum, 1'b0};
    hi_d    = win_end ? '0 : hi_sum;
    det_d   = det_q;
    if (win_end) begin
      if (hi_dbl < WIN_LEN)      det_d = POL_POS;
      else if (hi_dbl > WIN_LEN) det_d = POL_NEG;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      hi_q  <= '0;
      det_q <= POL_POS;
    end else begin
      win_q <= win_d;
      hi_q  <= hi_d;
      det_q <= det_d;
    end
  end

  assign pol_o = det_q;

  // R7: the status only changes at the end of a window
  p_det_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !win_end |=> $stable(det_q));
endmodule

// File: rtl/cwg_post_window.sv
module cwg_post_window #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             hs_rise_i,
  input  logic             vs_fall_i,
  input  logic [CNT_W-1:0] post_lines_i,
  output logic             post_act_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (vs_fall_i)                    cnt_d = post_lines_i;
    else if (hs_rise_i && cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign post_act_o = vs_fall_i ? (post_lines_i != '0) : (cnt_q != '0);

  // R5: the vertical fall loads the late-window length
  p_post_load_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    vs_fall_i |=> cnt_q == $past(post_lines_i));
  // R5, R10: one step down per horizontal edge outside a vertical fall
  p_post_step_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (hs_rise_i && !vs_fall_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen
  import cwg_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int SET_W  = 8,
  parameter int WIN_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             coast_ext_i,
  input  logic [SET_W-1:0] pre_lines_i,
  input  logic [SET_W-1:0] post_lines_i,
  input  logic             pol_force_i,
  input  logic             pol_user_i,
  output logic             coast_o,
  output logic             coast_pol_det_o
);
  localparam int SUM_W = ((LINE_W > SET_W) ? LINE_W : SET_W) + 1;

  logic              rst_m_q, rst_s_q;
  logic              hs_q, vs_q, hs_rise, vs_rise, vs_fall;
  logic [LINE_W-1:0] line_cnt, frame_len;
  logic              len_valid, pre_act, post_act, ext_act, ext_pol, coast_d, coast_q;
  logic [SUM_W-1:0]  reach;
  pol_e              det_pol;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hsync_i;
      vs_q <= vsync_i;
    end
  end

  assign hs_rise = hsync_i & ~hs_q;
  assign vs_rise = vsync_i & ~vs_q;
  assign vs_fall = ~vsync_i & vs_q;

  cwg_line_track #(.LINE_W(LINE_W)) u_line (
    .clk        (clk),
    .rst_ni     (rst_s_q),
    .hs_rise_i  (hs_rise),
    .vs_rise_i  (vs_rise),
    .line_cnt_o (line_cnt),
    .frame_len_o(frame_len),
    .len_valid_o(len_valid)
  );

  cwg_post_window #(.CNT_W(SET_W)) u_post (
    .clk         (clk),
    .rst_ni      (rst_s_q),
    .hs_rise_i   (hs_rise),
    .vs_fall_i   (vs_fall),
    .post_lines_i(post_lines_i),
    .post_act_o  (post_act)
  );

  cwg_pol_detect #(.WIN_W(WIN_W)) u_pol (
    .clk    (clk),
    .rst_ni (rst_s_q),
    .level_i(coast_ext_i),
    .pol_o  (det_pol)
  );

  always_comb begin
    reach   = SUM_W'(line_cnt) + SUM_W'(pre_lines_i);
    pre_act = len_valid && (pre_lines_i != '0) && (reach >= SUM_W'(frame_len));
    ext_pol = pol_force_i ? pol_user_i : (det_pol == POL_POS);
    ext_act = (coast_ext_i == ext_pol);
    coast_d = vsync_i | pre_act | post_act | ext_act;
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) coast_q <= 1'b0;
    else          coast_q <= coast_d;
  end

  assign coast_o         = coast_q;
  assign coast_pol_det_o = (det_pol == POL_POS);

  // R3: vertical sync always coasts
  p_vsync_coast_r3: assert property (@(posedge clk) disable iff (!rst_s_q)
    vsync_i |=> coast_o);
  // R6: a forced active-high external request always coasts
  p_ext_forced_r6: assert property (@(posedge clk) disable iff (!rst_s_q)
    (pol_force_i && pol_user_i && coast_ext_i) |=> coast_o);
  // R9: nothing but sync, late window and external input before measurement
  p_no_pre_unmeasured_r9: assert property (@(posedge clk) disable iff (!rst_s_q)
    (!len_valid && !vsync_i && !post_act && !ext_act) |=> !coast_o);
endmodule

// File: tb/test_coast_window_gen.sv
module test_coast_window_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0, vsync = 1'b0, ext = 1'b0;
  logic [7:0] pre_l = 8'd0, post_l = 8'd0;
  logic       pforce = 1'b0, puser = 1'b1;
  logic       coast, pdet;

  int checks = 0, fails = 0;
  bit done = 0;
  int ext_mode = 2;

  always #2 clk = ~clk;

  coast_window_gen i_coast_window_gen (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .coast_ext_i(ext), .pre_lines_i(pre_l), .post_lines_i(post_l),
    .pol_force_i(pforce), .pol_user_i(puser),
    .coast_o(coast), .coast_pol_det_o(pdet)
  );

  // requirement model
  bit m_rs1, m_rs2, m_hsq, m_vsq, m_started, m_valid, m_coast, m_det = 1;
  bit m_coinc;
  int m_cnt, m_len, m_post, m_win, m_hi;
  string m_tag = "R8";

  function automatic bit pre_open(int cnt, int len, bit valid, int pre);
    return valid && pre != 0 && (cnt + pre >= len);     // R4, R9
  endfunction

  function automatic bit pol_next(bit old, int hi, int win);
    if (2 * hi < win) return 1'b1;                        // R7
    if (2 * hi > win) return 1'b0;
    return old;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit old_rs2, hr, vr, vf, pr, po, ep, ea;
    old_rs2 = m_rs2;
    if (!rst_n) begin m_rs1 = 0; m_rs2 = 0; end
    else begin m_rs2 = m_rs1; m_rs1 = 1; end
    if (!old_rs2 || !rst_n) begin
      m_hsq = 0; m_vsq = 0; m_started = 0; m_valid = 0; m_coast = 0;
      m_det = 1; m_cnt = 0; m_len = 0; m_post = 0; m_win = 0; m_hi = 0; m_coinc = 0;
    end else begin
      hr = hsync & !m_hsq; vr = vsync & !m_vsq; vf = !vsync & m_vsq;
      pr = pre_open(m_cnt, m_len, m_valid, pre_l);
      po = vf ? (post_l != 0) : (m_post != 0);
      ep = pforce ? puser : m_det;
      ea = (ext == ep);
      m_coast = vsync | pr | po | ea;
      if (vsync) m_tag = "R3"; else if (pr) m_tag = "R2 R4";
      else if (po) m_tag = "R5"; else if (ea) m_tag = "R6";
      else if (!m_valid && pre_l != 0) m_tag = "R9"; else m_tag = "R8";
      if (m_coinc) m_tag = {m_tag, " R10"};
      if (hr && (vr || vf)) m_coinc = 1; else if (vr) m_coinc = 0;
      // R2 line tracking
      if (vr) begin
        if (m_started) begin m_len = m_cnt; m_valid = 1; end
        m_started = 1; m_cnt = 0;
      end else if (hr && m_cnt != 2047) m_cnt++;
      // R5 late window
      if (vf) m_post = post_l; else if (hr && m_post != 0) m_post--;
      // R7 detector
      if (m_win == 255) begin
        m_det = pol_next(m_det, m_hi + ext, 256); m_hi = 0; m_win = 0;
      end else begin m_hi += ext; m_win++; end
      m_hsq = hsync; m_vsq = vsync;
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_rs2 && !done) begin
      checks++;
      if (coast !== m_coast) begin
        fails++;
        $display("FAIL %s coast_o actual=%b expected=%b at %0t", m_tag, coast, m_coast, $time);
      end
      checks++;
      if (pdet !== m_det) begin
        fails++;
        $display("FAIL R7 coast_pol_det_o actual=%b expected=%b at %0t", pdet, m_det, $time);
      end
    end
  end

  // external coast stimulus
  initial begin
    forever begin
      @(negedge clk);
      case (ext_mode)
        0: ext = ($urandom % 8) == 0;
        1: ext = ($urandom % 8) != 0;
        3: ext = $urandom % 2;
        default: ext = 1'b0;
      endcase
    end
  end

  // one frame: vertical interval starts at line 0, cycle voff
  task automatic frame(int lines, int vlines, int voff);
    for (int l = 0; l < lines; l++) begin
      for (int c = 0; c < 16; c++) begin
        int t;
        @(negedge clk);
        t = l * 16 + c;
        hsync = (c < 2);
        vsync = (t >= voff) && (t < vlines * 16 + voff);
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checks++;                                              // R1 reset state
    if (coast !== 1'b0 || pdet !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b%b expected=01", coast, pdet);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (coast !== 1'b0 || pdet !== 1'b1) begin
      fails++;
      $display("FAIL R1 after release actual=%b%b expected=01", coast, pdet);
    end
    // R9: pre set before any measurement
    pre_l = 8'd5; post_l = 8'd2; ext_mode = 2; pforce = 1'b0;
    frame(30, 3, 4);
    frame(30, 3, 4);
    // R10: vertical edges on a horizontal rising edge
    frame(30, 3, 0);
    frame(30, 3, 0);
    // R4 boundaries: no early window, and an early window longer than the frame
    pre_l = 8'd0; frame(30, 3, 0);
    pre_l = 8'd40; frame(30, 3, 5);
    pre_l = 8'd1; post_l = 8'd0; frame(30, 3, 5);
    // R6, R7: detected and forced external polarity
    for (int m = 0; m < 4; m++) begin
      ext_mode = m;
      pforce = 1'b0; frame(32, 2, 3);
      pforce = 1'b1; puser = m[0]; frame(32, 2, 0);
      pforce = 1'b0; frame(32, 2, 7);
    end
    // constrained random frames
    ext_mode = 2;
    for (int f = 0; f < 40; f++) begin
      pre_l  = 8'($urandom % 12);
      post_l = 8'($urandom % 7);
      if (f % 10 == 9) begin ext_mode = int'($urandom % 4); pforce = $urandom % 2; puser = $urandom % 2; end
      frame(20 + int'($urandom % 20), 1 + int'($urandom % 4), int'($urandom % 3) * 2);
    end
    // R1: asynchronous reset in mid-frame
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    checks++;
    if (coast !== 1'b0 || pdet !== 1'b1) begin
      fails++;
      $display("FAIL R1 mid-run reset actual=%b%b expected=01", coast, pdet);
    end
    done = 1;
    summary();
  end
endmodule